// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the 16x oversampling strobe for a UART from a fixed functional clock. It has two stages. The first is a fractional pass stage that lets through a programmable share of the input clock edges, FDV/512 of them. The second is an integer reload divider that counts those passed edges and fires once every reload+1 of them. A small divide-by-16 stage turns the oversample strobe into a bit-rate strobe. The resulting bit rate is fclk·FDV/(8192·(reload+1)). Any rate requested from the generator must lie below fclk/16.

All configuration arrives through a narrow register write port. A control word holds the run bit and the fractional-mode bit. Two further words hold the 13-bit reload value and the 9-bit fraction value. Software clears run, rewrites the divisor pair, and then sets run again. While run is set, the divisor registers are locked. Clearing run also returns both stages to their idle state, so every restart begins a complete period from zero.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the run bit, fractional-mode bit, reload and fraction registers are all zero, and `os_tick_o` and `bit_tick_o` stay low.
- R2: Write address 0 is control, with bit 0 as run and bit 1 as fractional mode. Address 1 holds the reload value in data bits [12:0] and address 2 holds the fraction in data bits [8:0]. A write to address 3 has no effect.
- R3: With fractional mode on and a fraction F from 1 to 511, the number of edges passed in the first k clocks after run is set is floor(k·F/512).
- R4: With fractional mode on and a fraction of 0, every clock edge is passed, as if F were 512.
- R5: With fractional mode off, every clock edge is passed whatever the fraction register holds.
- R6: The n-th oversample strobe follows the clock edge that passes edge number n·(reload+1). It is high for the single cycle after that edge, so the reload value gives a divisor of reload+1.
- R7: `bit_tick_o` pulses for one cycle, one cycle after every 16th oversample strobe.
- R8: Clearing run stops both strobes and clears the accumulator, the reload counter and the divide-by-16 counter. After run is set again, the first strobe comes a full period after the restart.
- R9: Writes to the reload or fraction register are ignored while run is set. Control writes always take effect.
- R10: A reload value of 8191 gives a divisor of 8192, with the first strobe on the 8192nd passed edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| os_tick_o | output | 1 | 16x oversample strobe |
| bit_tick_o | output | 1 | Bit-rate strobe |

## Verification
The assertions check several rules on every cycle:
- the divisor registers do not move while run is set;
- every clock edge is passed in integer mode and when the fraction is zero;
- an idle generator holds a clear accumulator and a silent strobe;
- the reload counter never exceeds the reload value;
- each oversample strobe follows a passed edge, and each bit strobe follows an oversample strobe.

The exact placement of the strobes cannot be expressed as a short property. This covers the floor(k·F/512) spacing of fractional pacing, the full-period restart and the 8192 divisor. Only the bench scenarios show these, by comparing every strobe against the cycle predicted by the rate formula.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_FRAC   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_FRAC_BIT = 1;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int unsigned RELOAD_W = 13,
  parameter int unsigned FRAC_W   = 9,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                run_o,
  output logic                frac_en_o,
  output logic [RELOAD_W-1:0] reload_o,
  output logic [FRAC_W-1:0]   frac_o
);
  logic                run_q;
  logic                frac_en_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [FRAC_W-1:0]   frac_q;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      frac_en_q <= 1'b0;
      reload_q  <= '0;
      frac_q    <= '0;
    end else if (wr_en_i) begin
      case (sel)
        REG_CTRL: begin
          run_q     <= wr_data_i[CTRL_RUN_BIT];
          frac_en_q <= wr_data_i[CTRL_FRAC_BIT];
        end
        // divisor pair is locked while the generator runs
        REG_RELOAD: if (!run_q) reload_q <= wr_data_i[RELOAD_W-1:0];
        REG_FRAC:   if (!run_q) frac_q   <= wr_data_i[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  logic unused_wr_data;
  assign unused_wr_data = ^wr_data_i;

  assign run_o     = run_q;
  assign frac_en_o = frac_en_q;
  assign reload_o  = reload_q;
  assign frac_o    = frac_q;
endmodule

// File: rtl/frac_baud_frac_stage.sv
module frac_baud_frac_stage #(
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              frac_en_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              pass_o,
  output logic [FRAC_W-1:0] acc_o
);
  localparam int unsigned SUM_W = FRAC_W + 1;
  localparam logic [SUM_W-1:0] FULL_STEP = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  step;
  logic [SUM_W-1:0]  sum;

  // zero fraction or integer mode: full-rate step, carry on every edge
  always_comb begin
    if (!frac_en_i || (frac_i == '0)) step = FULL_STEP;
    else                              step = {1'b0, frac_i};
    sum = {1'b0, acc_q} + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else             acc_q <= sum[FRAC_W-1:0];
  end

  assign pass_o = run_i & sum[FRAC_W];
  assign acc_o  = acc_q;
endmodule

// File: rtl/frac_baud_reload_div.sv
module frac_baud_reload_div #(
  parameter int unsigned RELOAD_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                pass_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick_o,
  output logic [RELOAD_W-1:0] cnt_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= reload_i;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (pass_i) begin
        if (cnt_q == '0) begin
          cnt_q  <= reload_i;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/frac_baud_bit_div.sv
module frac_baud_bit_div #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_tick_o
);
  localparam int unsigned DIV_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(RATIO - 1);

  logic [DIV_W-1:0] div_q;
  logic             bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= 1'b0;
    end else begin
      bit_q <= tick_i && (div_q == LAST);
      if (!run_i)          div_q <= '0;
      else if (tick_i) begin
        if (div_q == LAST) div_q <= '0;
        else               div_q <= div_q + 1'b1;
      end
    end
  end

  assign bit_tick_o = bit_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned RELOAD_W   = 13,
  parameter int unsigned FRAC_W     = 9,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  logic                run_q;
  logic                frac_en_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [FRAC_W-1:0]   frac_q;
  logic                pass;
  logic [FRAC_W-1:0]   acc;
  logic [RELOAD_W-1:0] cnt;

  frac_baud_regs #(
    .RELOAD_W(RELOAD_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .run_o(run_q), .frac_en_o(frac_en_q), .reload_o(reload_q), .frac_o(frac_q)
  );

  frac_baud_frac_stage #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i, .rst_ni, .run_i(run_q), .frac_en_i(frac_en_q), .frac_i(frac_q),
    .pass_o(pass), .acc_o(acc)
  );

  frac_baud_reload_div #(.RELOAD_W(RELOAD_W)) u_reload (
    .clk_i, .rst_ni, .run_i(run_q), .pass_i(pass), .reload_i(reload_q),
    .tick_o(os_tick_o), .cnt_o(cnt)
  );

  frac_baud_bit_div #(.RATIO(OVERSAMPLE)) u_bit (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i(os_tick_o), .bit_tick_o(bit_tick_o)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int unsigned RELOAD_W = 13,
  parameter int unsigned FRAC_W   = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                run_i,
  input logic                frac_en_i,
  input logic [RELOAD_W-1:0] reload_i,
  input logic [FRAC_W-1:0]   frac_i,
  input logic                pass_i,
  input logic [FRAC_W-1:0]   acc_i,
  input logic [RELOAD_W-1:0] cnt_i,
  input logic                os_tick_i,
  input logic                bit_tick_i
);
  assert_locked_divisor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(reload_i) && $stable(frac_i)));

  // R4 and R5: full-rate pass
  assert_full_rate_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (!frac_en_i || (frac_i == '0))) |-> pass_i);

  assert_idle_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((acc_i == '0) && !os_tick_i));

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= reload_i));

  assert_tick_after_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_tick_i |-> $past(pass_i));

  assert_bit_after_os_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i |-> $past(os_tick_i));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.RELOAD_W(RELOAD_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .frac_en_i(frac_en_q),
  .reload_i(reload_q), .frac_i(frac_q), .pass_i(pass), .acc_i(acc), .cnt_i(cnt),
  .os_tick_i(os_tick_o), .bit_tick_i(bit_tick_o)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        os_tick, bit_tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";
  int exp_os[$];
  int exp_bit[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen u_frac_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .os_tick_o(os_tick), .bit_tick_o(bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && armed) begin
      if (exp_os.size() > 0 && exp_os[0] < cyc) begin
        check(1'b0, cur_req, "missed os tick at cycle", cyc, exp_os[0]);
        void'(exp_os.pop_front());
      end
      if (os_tick) begin
        if (exp_os.size() == 0) check(1'b0, cur_req, "unexpected os tick at cycle", cyc, -1);
        else begin
          check(exp_os[0] == cyc, cur_req, "os tick cycle", cyc, exp_os[0]);
          void'(exp_os.pop_front());
        end
      end
      if (exp_bit.size() > 0 && exp_bit[0] < cyc) begin
        check(1'b0, "R7", "missed bit tick at cycle", cyc, exp_bit[0]);
        void'(exp_bit.pop_front());
      end
      if (bit_tick) begin
        if (exp_bit.size() == 0) check(1'b0, "R7", "unexpected bit tick at cycle", cyc, -1);
        else begin
          check(exp_bit[0] == cyc, "R7", "bit tick cycle", cyc, exp_bit[0]);
          void'(exp_bit.pop_front());
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  // expected clock edge of pass number p for effective step f
  function automatic int edge_of(input longint p, input int f);
    return int'((p * 512 + f - 1) / f);
  endfunction

  task automatic run_case(input string req, input bit fe, input int frac,
                          input int rel, input int w, input bit mid);
    int t0;
    int f;
    cur_req = req;
    wr(2'd1, 16'(rel));
    wr(2'd2, 16'(frac));
    wr(2'd0, {14'd0, fe, 1'b1});
    t0 = cyc;
    f = (!fe || frac == 0) ? 512 : frac;
    for (int n = 1; ; n++) begin
      int k;
      k = edge_of(longint'(n) * (rel + 1), f);
      if (k > w + 1) break;
      exp_os.push_back(t0 + k);
      if (n % 16 == 0) exp_bit.push_back(t0 + k + 1);
    end
    if (mid) begin
      repeat (w / 2) @(negedge clk);
      wr(2'd1, 16'd7);       // R9: ignored while running
      wr(2'd3, 16'hffff);    // R2: spare address
      wr(2'd2, 16'd50);      // R9: ignored while running
      repeat (w - w / 2 - 3) @(negedge clk);
    end else begin
      repeat (w) @(negedge clk);
    end
    wr(2'd0, {14'd0, fe, 1'b0});
    repeat (40) @(negedge clk);
    check(exp_os.size() == 0, req, "os ticks left pending", exp_os.size(), 0);
    check(exp_bit.size() == 0, "R7", "bit ticks left pending", exp_bit.size(), 0);
    exp_os.delete();
    exp_bit.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      check(os_tick == 1'b0, "R1", "os tick after reset", int'(os_tick), 0);
      check(bit_tick == 1'b0, "R1", "bit tick after reset", int'(bit_tick), 0);
      @(negedge clk);
    end
    armed = 1'b1;
    // R2: spare address must not start the generator
    cur_req = "R2";
    wr(2'd3, 16'hffff);
    repeat (30) @(negedge clk);
    check(exp_os.size() == 0, "R2", "queue idle", exp_os.size(), 0);

    run_case("R5", 1'b0, 100, 2, 200, 1'b0);
    run_case("R4", 1'b1, 0, 0, 100, 1'b0);
    run_case("R3", 1'b1, 300, 4, 600, 1'b0);
    run_case("R3", 1'b1, 1, 0, 1100, 1'b0);
    run_case("R9", 1'b1, 200, 3, 400, 1'b1);
    // R8: restart with the same pair, counted from the new start
    run_case("R8", 1'b1, 200, 3, 150, 1'b0);
    run_case("R6", 1'b0, 0, 5, 300, 1'b0);
    run_case("R10", 1'b0, 0, 8191, 8200, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule